// File: doc/BRIEF.md
# Glitch-Free Two-Clock Switch

This block chooses one of two unrelated clocks and passes it to a single clock output. It is built for the case where the output drives a clock line that leaves the chip, so the output must never show a glitch or a shortened pulse. The pad driver enable that comes with the output stays off until the switch has settled after reset.

The choice is made by a small three-state controller: the A clock is passed, no clock is passed, or the B clock is passed. A change of choice closes the gate of the clock being left. This step is taken by logic clocked by that clock. The closed state is then synchronised into the domain of the clock being entered, and only then does logic clocked by the new clock open its gate. Each gate flop updates on the falling edge of its own clock, so a gate only opens or closes while its clock is low. A select change that arrives in the middle of a handoff is held back. It takes effect once the current handoff has finished.

Top module: `clk_switch2`

## Requirements
- R1: While `rst_n` is low, `clk_out` and `pad_oe` are both held at 0.
- R2: After reset is released with `sel` at 0 (0 chooses A, 1 chooses B), `clk_out` follows `clk_a`.
- R3: `pad_oe` goes to 1 on the 4th rising edge of `clk_out` after the A gate first opens. It then stays at 1 until the next reset, through every later switch.
- R4: After `sel` goes to 1, `clk_out` settles to the period of `clk_b`. After `sel` goes back to 0, it settles to the period of `clk_a`.
- R5: The two gates are never open at the same time. Every handoff contains an idle gap in which `clk_out` stays low for longer than a normal low phase of either clock.
- R6: Every high pulse on `clk_out` is exactly one full high phase of the chosen source clock. Every low phase is at least the shorter of the two half-periods. No runt pulse ever appears.
- R7: If `sel` changes back while a handoff is still in progress, the handoff first completes to the clock it was heading for, and only then does the block switch again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | First source clock, chosen when sel is 0 |
| clk_b | input | 1 | Second source clock, unrelated to clk_a, chosen when sel is 1 |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Asynchronous clock choice: 0 for A, 1 for B |
| clk_out | output | 1 | Switched clock output |
| pad_oe | output | 1 | Enable for the tri-state pad that drives clk_out off chip |

## Verification
The two source clocks run at 20 ns and 14 ns with a phase offset, so they have no fixed relation. The patterns are a plain start-up on A, a switch from A to B, a switch back to B to A, and a select that reverses after the handoff has been committed. The measured period tells which source is live, and the longest low interval during a handoff shows the idle step. Every pulse on the output is timed throughout the run, so a gate that opens or closes while its clock is high shows up as a high pulse that matches neither half-period.

// File: rtl/clk_switch2.sv
module clk_switch2 #(
  parameter int SYNC_STAGES = 2,
  parameter int OE_DELAY    = 4
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst_n,
  input  logic sel,
  output logic clk_out,
  output logic pad_oe
);
  localparam int CW = $clog2(OE_DELAY + 1);

  logic [SYNC_STAGES-1:0] sel_sa, gb_sa, tg_sb, ga_sb;
  logic tgt, en_a, en_b, gate_a, gate_b, oe;
  logic [CW-1:0] cnt;

  wire sel_a  = sel_sa[SYNC_STAGES-1];
  wire b_seen = gb_sa[SYNC_STAGES-1];
  wire tgt_b  = tg_sb[SYNC_STAGES-1];
  wire a_seen = ga_sb[SYNC_STAGES-1];
  wire settled = tgt ? (!gate_a && b_seen) : (gate_a && !b_seen);

  // A domain: target choice, leave/enter decision for A, pad enable delay
  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) begin
      sel_sa <= '0;
      gb_sa  <= '0;
      tgt    <= 1'b0;
      en_a   <= 1'b0;
      cnt    <= '0;
      oe     <= 1'b0;
    end else begin
      sel_sa <= {sel_sa[SYNC_STAGES-2:0], sel};
      gb_sa  <= {gb_sa[SYNC_STAGES-2:0], gate_b};
      if (settled) tgt <= sel_a;
      en_a <= !tgt && !b_seen;
      if (gate_a && !oe) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(OE_DELAY - 1)) oe <= 1'b1;
      end
    end
  end

  always_ff @(negedge clk_a or negedge rst_n) begin
    if (!rst_n) gate_a <= 1'b0;
    else        gate_a <= en_a;
  end

  // B domain: sees the target and the A gate, opens B only once A is shut
  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      tg_sb <= '0;
      ga_sb <= '0;
      en_b  <= 1'b0;
    end else begin
      tg_sb <= {tg_sb[SYNC_STAGES-2:0], tgt};
      ga_sb <= {ga_sb[SYNC_STAGES-2:0], gate_a};
      en_b  <= tgt_b && !a_seen;
    end
  end

  always_ff @(negedge clk_b or negedge rst_n) begin
    if (!rst_n) gate_b <= 1'b0;
    else        gate_b <= en_b;
  end

  assign clk_out = (clk_a & gate_a) | (clk_b & gate_b);
  assign pad_oe  = oe;

  // R5: gates never open together, seen from either clock
  a_r5_excl_a: assert property (@(negedge clk_a) disable iff (!rst_n) gate_a |-> !gate_b);
  a_r5_excl_b: assert property (@(negedge clk_b) disable iff (!rst_n) gate_b |-> !gate_a);
  // R3: pad enable is sticky and first rises while A is passed
  a_r3_oe_sticky: assert property (@(posedge clk_a) disable iff (!rst_n) oe |=> oe);
  a_r3_oe_on_a: assert property (@(posedge clk_a) disable iff (!rst_n) $rose(oe) |-> gate_a);
  // R7: target only moves once the previous handoff has landed
  a_r7_hold_target: assert property (@(posedge clk_a) disable iff (!rst_n)
    (tgt != $past(tgt)) |-> ($past(gate_a) != $past(b_seen)));
endmodule

// File: tb/clk_switch2_test.sv
`timescale 1ns/1ps
module clk_switch2_test;
  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0, sel = 1'b0;
  logic clk_out, pad_oe;
  int checks = 0, failures = 0;
  int bad_pulses = 0, b_pulses = 0, pre_oe_edges = 0;
  realtime t_rise = 0, t_fall = 0, max_low = 0, bad_w = 0;
  bit started = 0;

  clk_switch2 uut (.clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .sel(sel),
                   .clk_out(clk_out), .pad_oe(pad_oe));

  always #10 clk_a = ~clk_a;
  initial begin #3; forever #7 clk_b = ~clk_b; end

  function automatic bit near(realtime x, realtime y);
    return (x > y - 0.01) && (x < y + 0.01);
  endfunction

  // pulse monitor for R6
  always @(posedge clk_out) begin
    if (!pad_oe) pre_oe_edges++;
    if (started) begin
      if (t_rise - t_fall > 0 || t_fall > 0) begin
        if ($realtime - t_fall < 6.99) begin bad_pulses++; bad_w = $realtime - t_fall; end
        if ($realtime - t_fall > max_low) max_low = $realtime - t_fall;
      end
    end
    started = 1;
    t_rise = $realtime;
  end
  always @(negedge clk_out) begin
    if (!near($realtime - t_rise, 10.0) && !near($realtime - t_rise, 7.0)) begin
      bad_pulses++; bad_w = $realtime - t_rise;
    end
    if (near($realtime - t_rise, 7.0)) b_pulses++;
    t_fall = $realtime;
  end

  task automatic check(bit ok, string req, string what, real act, real exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0.2f expected=%0.2f", req, what, act, exp);
    end
  endtask

  task automatic measure_period(output realtime p);
    realtime t1;
    @(posedge clk_out); t1 = $realtime;
    @(posedge clk_out); p = $realtime - t1;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) begin
      #13;
      check(clk_out == 1'b0, "R1", "clk_out in reset", clk_out, 0);
      check(pad_oe == 1'b0, "R1", "pad_oe in reset", pad_oe, 0);
    end
  endtask

  task automatic t_start_a;
    realtime p;
    #5 rst_n = 1'b1;
    #300;
    measure_period(p);
    check(near(p, 20.0), "R2", "period after reset", p, 20.0);
    check(pad_oe == 1'b1, "R3", "pad_oe after start", pad_oe, 1);
    check(pre_oe_edges == 4, "R3", "edges before pad_oe", pre_oe_edges, 4);
  endtask

  task automatic t_to_b;
    realtime p;
    max_low = 0;
    sel = 1'b1;
    #400;
    measure_period(p);
    check(near(p, 14.0), "R4", "period after sel=1", p, 14.0);
    check(max_low > 10.5, "R5", "idle gap A->B", max_low, 10.5);
    check(pad_oe == 1'b1, "R3", "pad_oe held after switch", pad_oe, 1);
  endtask

  task automatic t_to_a;
    realtime p;
    max_low = 0;
    sel = 1'b0;
    #400;
    measure_period(p);
    check(near(p, 20.0), "R4", "period after sel=0", p, 20.0);
    check(max_low > 10.5, "R5", "idle gap B->A", max_low, 10.5);
  endtask

  task automatic t_midswitch;
    realtime p;
    b_pulses = 0;
    @(negedge clk_a);
    sel = 1'b1;
    repeat (3) @(posedge clk_a);
    #1 sel = 1'b0;
    #600;
    check(b_pulses > 0, "R7", "B visited before return", b_pulses, 1);
    measure_period(p);
    check(near(p, 20.0), "R7", "period after reversed select", p, 20.0);
    check(pad_oe == 1'b1, "R3", "pad_oe after reversal", pad_oe, 1);
  endtask

  initial begin
    #1_000_000;
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_start_a();
    t_to_b();
    t_to_a();
    t_midswitch();
    t_to_b();
    t_to_a();
    check(bad_pulses == 0, "R6", "runt or misshaped pulses", bad_w, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule